// File: doc/BRIEF.md
# Removable Device Bay Controller

This block looks after a single hot-plug device bay. Two active-low presence lines tell it whether an inserted device uses the USB interface, the 1394 interface or both, and a pushbutton on the bay lets the user ask for removal. Every one of these inputs is synchronised and debounced before the block acts on it. A change in presence raises a sticky status-change flag, and a button press latches a removal event. Either one raises the interrupt output.

Software drives the bay through a small register port. It writes a lock bit, an ID-power bit and a state request, and it reads back status. Hardware keeps the power bit tied to the lock. It accepts a state request only while a device is present, applies it on the write cycle itself, and keeps the last nonzero request code for read-back. It never leaves the empty state without software.

A bay indicator output blinks while an insertion is being handled and is solid once ID power is on. It blinks again on a removal request while power is still on, and goes dark once power is off or the system enters a low-power state.

Top module: `bay_mgr`

## Requirements
- R1: Presence inputs are active low. A level counts only after a two-flop synchroniser and DEBOUNCE_CYC consecutive stable cycles, so shorter glitches are ignored. Filtered presence reads as active-high in status (address 1): bit 2 is USB and bit 3 is 1394.
- R2: Any change of the filtered presence pair sets the change flag (status bit 0). The flag holds until a write of 1 to bit 0 of address 1. A new change in the same cycle wins over the clear.
- R3: Bay state (status bits 5:4; 0 empty, 1 inserted, 2 powered, 3 removing) stays empty until software requests otherwise. When presence is lost, the state returns to empty and ID power clears.
- R4: The request field (address 0, bits 3:2) moves the state to the written code in the cycle of the write, but only when a device is present. Otherwise the request is ignored. A value of 0 has no effect. The field reads back the last nonzero value written.
- R5: Address 0 bit 0 is the lock bit and drives lock_o. Bit 1 is ID power and drives pwr_o. Power is set only if the same write sets the lock, and clearing the lock clears power in the same cycle.
- R6: While override_i is high, ID power is forced clear, and writes cannot set it.
- R7: A filtered button press sets the removal event (status bit 1, cleared by writing 1 to it). The press leaves power, lock and state unchanged.
- R8: irq_o is high whenever the change flag or the removal event is set.
- R9: The indicator is solid while power is on. It blinks, toggling every BLINK_DIV cycles, while power is on and a removal event is pending or the state is removing. It also blinks in the inserted state with power off. Otherwise it is off.
- R10: low_pwr_i forces the indicator off whatever the bay state.
- R11: After reset, lock, power, state, request read-back, both flags and the indicator are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prsn_usb_ni | input | 1 | USB-type presence, active low |
| prsn_fw_ni | input | 1 | 1394-type presence, active low |
| rem_btn_i | input | 1 | Removal pushbutton, high when pressed |
| override_i | input | 1 | Interlock override, forces power off |
| low_pwr_i | input | 1 | System low-power state, indicator off |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address (0 control, 1 status) |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i |
| lock_o | output | 1 | Lock enable |
| pwr_o | output | 1 | ID-power enable |
| led_o | output | 1 | Bay indicator |
| irq_o | output | 1 | Interrupt |

## Verification
The assertions assume that override_i and low_pwr_i are already synchronous to clk_i. They also assume writes are single-cycle strobes whose address and data are stable at the sampling edge. The bench drives every input on the falling edge, so these conditions always hold at the rising edge. It holds presence and button levels for well over the debounce window, apart from glitches that are deliberately short. The bench also keeps writes away from the few cycles in which filtered presence is itself changing.

// File: rtl/bay_pkg.sv
package bay_pkg;
  typedef enum logic [1:0] {
    BAY_EMPTY    = 2'd0,
    BAY_INSERTED = 2'd1,
    BAY_POWERED  = 2'd2,
    BAY_REMOVING = 2'd3
  } bay_state_e;

  typedef enum logic [1:0] {
    IND_OFF   = 2'd0,
    IND_SOLID = 2'd1,
    IND_BLINK = 2'd2
  } ind_mode_e;

  localparam int REG_CTRL = 0;
  localparam int REG_STAT = 1;

  localparam int CTRL_LOCK  = 0;
  localparam int CTRL_PWR   = 1;
  localparam int CTRL_REQ   = 2;
  localparam int STAT_CHG   = 0;
  localparam int STAT_REM   = 1;
  localparam int STAT_USB   = 2;
  localparam int STAT_FW    = 3;
  localparam int STAT_STATE = 4;
  localparam int REQ_W      = 2;
  localparam int FIELD_TOP  = 5;
endpackage

// File: rtl/bay_in_filter.sv
module bay_in_filter #(
  parameter int   DEB_CYC = 16,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CNT_W = (DEB_CYC < 2) ? 1 : $clog2(DEB_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYC - 1);

  logic             s1_q, s2_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= RST_VAL;
      s2_q   <= RST_VAL;
      filt_o <= RST_VAL;
      cnt_q  <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      if (s2_q == filt_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
        filt_o <= s2_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bay_core.sv
module bay_core
  import bay_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ctrl_i,
  input  logic             wr_stat_i,
  input  logic [3:0]       wfield_i,
  input  logic             override_i,
  input  logic [1:0]       pres_i,
  input  logic             btn_i,
  output logic             lock_o,
  output logic             pwr_o,
  output logic [REQ_W-1:0] req_last_o,
  output bay_state_e       state_o,
  output logic             chg_o,
  output logic             rem_o
);
  logic [1:0]       pres_q;
  logic             btn_q;
  logic             present, was_present;
  logic [REQ_W-1:0] req;
  logic             req_nz;

  assign present     = |pres_i;
  assign was_present = |pres_q;
  assign req         = wfield_i[CTRL_REQ +: REQ_W];
  assign req_nz      = |req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pres_q     <= '0;
      btn_q      <= 1'b0;
      chg_o      <= 1'b0;
      rem_o      <= 1'b0;
      lock_o     <= 1'b0;
      pwr_o      <= 1'b0;
      req_last_o <= '0;
      state_o    <= BAY_EMPTY;
    end else begin
      pres_q <= pres_i;
      btn_q  <= btn_i;

      if (pres_i != pres_q)                 chg_o <= 1'b1;
      else if (wr_stat_i && wfield_i[STAT_CHG]) chg_o <= 1'b0;

      if (btn_i && !btn_q)                  rem_o <= 1'b1;
      else if (wr_stat_i && wfield_i[STAT_REM]) rem_o <= 1'b0;

      if (wr_ctrl_i) lock_o <= wfield_i[CTRL_LOCK];

      // power follows lock; absence or override kills it
      if (override_i || !present)
        pwr_o <= 1'b0;
      else if (wr_ctrl_i)
        pwr_o <= wfield_i[CTRL_PWR] & wfield_i[CTRL_LOCK];

      if (wr_ctrl_i && req_nz) req_last_o <= req;

      if (was_present && !present)
        state_o <= BAY_EMPTY;
      else if (wr_ctrl_i && req_nz && present)
        state_o <= bay_state_e'(req);
    end
  end
endmodule

// File: rtl/bay_indicator.sv
module bay_indicator
  import bay_pkg::*;
#(
  parameter int BLINK_DIV = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       low_pwr_i,
  input  logic       pwr_i,
  input  logic       rem_i,
  input  bay_state_e state_i,
  output logic       led_o
);
  localparam int DIV_W = (BLINK_DIV < 2) ? 1 : $clog2(BLINK_DIV);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(BLINK_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic             phase_q;
  ind_mode_e        mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      phase_q <= 1'b0;
    end else if (div_q == DIV_LAST) begin
      div_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  always_comb begin
    if (pwr_i && (rem_i || state_i == BAY_REMOVING)) mode = IND_BLINK;
    else if (pwr_i)                                  mode = IND_SOLID;
    else if (state_i == BAY_INSERTED)                mode = IND_BLINK;
    else                                             mode = IND_OFF;
  end

  always_comb begin
    if (low_pwr_i)              led_o = 1'b0;
    else if (mode == IND_SOLID) led_o = 1'b1;
    else if (mode == IND_BLINK) led_o = phase_q;
    else                        led_o = 1'b0;
  end
endmodule

// File: rtl/bay_mgr.sv
module bay_mgr
  import bay_pkg::*;
#(
  parameter int ADDR_W       = 2,
  parameter int DATA_W       = 8,
  parameter int DEBOUNCE_CYC = 16,
  parameter int BLINK_DIV    = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prsn_usb_ni,
  input  logic              prsn_fw_ni,
  input  logic              rem_btn_i,
  input  logic              override_i,
  input  logic              low_pwr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              lock_o,
  output logic              pwr_o,
  output logic              led_o,
  output logic              irq_o
);
  localparam int          N_IN     = 3;
  localparam logic [2:0]  FILT_RST = 3'b011;

  logic [N_IN-1:0]  raw_in, filt;
  logic [1:0]       pres;
  logic             wr_ctrl, wr_stat;
  logic [REQ_W-1:0] req_last;
  bay_state_e       bay_state;
  logic             chg, rem, dev_present;
  logic             unused_wdata;

  assign raw_in = {rem_btn_i, prsn_fw_ni, prsn_usb_ni};

  for (genvar gi = 0; gi < N_IN; gi++) begin : g_filt
    bay_in_filter #(
      .DEB_CYC (DEBOUNCE_CYC),
      .RST_VAL (FILT_RST[gi])
    ) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw_in[gi]),
      .filt_o (filt[gi])
    );
  end

  assign pres        = ~filt[1:0];
  assign dev_present = |pres;
  assign wr_ctrl     = wr_en_i && (addr_i == ADDR_W'(REG_CTRL));
  assign wr_stat     = wr_en_i && (addr_i == ADDR_W'(REG_STAT));
  assign unused_wdata = ^wdata_i[DATA_W-1:4];

  bay_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_ctrl_i  (wr_ctrl),
    .wr_stat_i  (wr_stat),
    .wfield_i   (wdata_i[3:0]),
    .override_i (override_i),
    .pres_i     (pres),
    .btn_i      (filt[2]),
    .lock_o     (lock_o),
    .pwr_o      (pwr_o),
    .req_last_o (req_last),
    .state_o    (bay_state),
    .chg_o      (chg),
    .rem_o      (rem)
  );

  bay_indicator #(.BLINK_DIV(BLINK_DIV)) u_ind (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .low_pwr_i (low_pwr_i),
    .pwr_i     (pwr_o),
    .rem_i     (rem),
    .state_i   (bay_state),
    .led_o     (led_o)
  );

  assign irq_o = chg | rem;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(REG_CTRL)) begin
      rdata_o[CTRL_LOCK]          = lock_o;
      rdata_o[CTRL_PWR]           = pwr_o;
      rdata_o[CTRL_REQ +: REQ_W]  = req_last;
    end else if (addr_i == ADDR_W'(REG_STAT)) begin
      rdata_o[STAT_CHG]           = chg;
      rdata_o[STAT_REM]           = rem;
      rdata_o[STAT_USB]           = pres[0];
      rdata_o[STAT_FW]            = pres[1];
      rdata_o[STAT_STATE +: 2]    = bay_state;
    end
  end
endmodule

// File: rtl/bay_mgr_chk.sv
module bay_mgr_chk
  import bay_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              override_i,
  input logic              low_pwr_i,
  input logic              lock_o,
  input logic              pwr_o,
  input logic              led_o,
  input bay_state_e        state_i,
  input logic              present_i
);
  logic             ctrl_wr;
  logic [REQ_W-1:0] wreq;
  assign ctrl_wr = wr_en_i && (addr_i == ADDR_W'(REG_CTRL));
  assign wreq    = wdata_i[CTRL_REQ +: REQ_W];

  assert_pwr_needs_lock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_o |-> lock_o);

  assert_override_kills_pwr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    override_i |=> !pwr_o);

  assert_empty_needs_sw_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == BAY_EMPTY && !(ctrl_wr && wreq != '0)) |=> state_i == BAY_EMPTY);

  assert_req_applies_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wreq != '0 && present_i) |=> state_i == bay_state_e'($past(wreq)));

  assert_low_pwr_dark_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_pwr_i |-> !led_o);
endmodule

bind bay_mgr bay_mgr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .override_i (override_i),
  .low_pwr_i  (low_pwr_i),
  .lock_o     (lock_o),
  .pwr_o      (pwr_o),
  .led_o      (led_o),
  .state_i    (bay_state),
  .present_i  (dev_present)
);

// File: tb/bay_mgr_bench.sv
`timescale 1ns/1ps
module bay_mgr_bench;
  localparam int DEB = 4;
  localparam int DIV = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       prsn_usb_ni = 1'b1, prsn_fw_ni = 1'b1, rem_btn_i = 1'b0;
  logic       override_i = 1'b0, low_pwr_i = 1'b0, wr_en_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       lock_o, pwr_o, led_o, irq_o;

  int vectors = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bay_mgr #(.ADDR_W(2), .DATA_W(8), .DEBOUNCE_CYC(DEB), .BLINK_DIV(DIV)) u_bay_mgr (
    .clk_i, .rst_ni, .prsn_usb_ni, .prsn_fw_ni, .rem_btn_i, .override_i,
    .low_pwr_i, .wr_en_i, .addr_i, .wdata_i, .rdata_o, .lock_o, .pwr_o,
    .led_o, .irq_o
  );

  // behavioural reference
  logic [2:0] rawq[$];
  int         run[3];
  logic [2:0] mf;
  logic [1:0] m_pvq, m_req, m_state;
  logic       m_btnq, m_chg, m_rem, m_lock, m_pwr;
  int         n_edges;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rawq.delete();
      for (int b = 0; b < 3; b++) run[b] = 0;
      mf = 3'b011; m_pvq = 0; m_req = 0; m_state = 0;
      m_btnq = 0; m_chg = 0; m_rem = 0; m_lock = 0; m_pwr = 0; n_edges = 0;
    end else begin
      logic [1:0] pv, rq;
      logic pres, btn, wc, ws, d;
      logic n_chg, n_rem, n_lock, n_pwr;
      logic [1:0] n_req, n_state;
      pv = {~mf[1], ~mf[0]}; pres = |pv; btn = mf[2];
      wc = wr_en_i && addr_i == 2'd0; ws = wr_en_i && addr_i == 2'd1;
      rq = wdata_i[3:2];
      n_chg  = (pv != m_pvq) ? 1'b1 : (ws && wdata_i[0]) ? 1'b0 : m_chg;
      n_rem  = (btn && !m_btnq) ? 1'b1 : (ws && wdata_i[1]) ? 1'b0 : m_rem;
      n_lock = wc ? wdata_i[0] : m_lock;
      n_pwr  = (override_i || !pres) ? 1'b0 : wc ? (wdata_i[1] & wdata_i[0]) : m_pwr;
      n_req  = (wc && rq != 0) ? rq : m_req;
      n_state = ((|m_pvq) && !pres) ? 2'd0 : (wc && rq != 0 && pres) ? rq : m_state;
      m_chg = n_chg; m_rem = n_rem; m_lock = n_lock; m_pwr = n_pwr;
      m_req = n_req; m_state = n_state; m_pvq = pv; m_btnq = btn;
      rawq.push_back({rem_btn_i, prsn_fw_ni, prsn_usb_ni});
      if (rawq.size() > 3) void'(rawq.pop_front());
      for (int b = 0; b < 3; b++) begin
        d = (rawq.size() == 3) ? rawq[0][b] : ((b == 2) ? 1'b0 : 1'b1);
        if (d != mf[b]) begin
          run[b]++;
          if (run[b] == DEB) begin mf[b] = d; run[b] = 0; end
        end else run[b] = 0;
      end
      n_edges++;
    end
  end

  function automatic logic exp_led();
    logic ph;
    ph = ((n_edges / DIV) % 2) == 1;
    if (low_pwr_i) return 1'b0;
    if (m_pwr && (m_rem || m_state == 2'd3)) return ph;
    if (m_pwr) return 1'b1;
    if (m_state == 2'd1) return ph;
    return 1'b0;
  endfunction

  task automatic cmp(string req, string what, logic [7:0] got, logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    #1;
    if (!done) begin
      cmp("R5", "lock_o", {7'd0, lock_o}, {7'd0, m_lock});
      cmp("R5", "pwr_o", {7'd0, pwr_o}, {7'd0, m_pwr});
      cmp("R8", "irq_o", {7'd0, irq_o}, {7'd0, m_chg | m_rem});
      cmp("R9", "led_o", {7'd0, led_o}, {7'd0, exp_led()});
      if (addr_i == 2'd0) begin
        cmp("R4", "ctrl req", {6'd0, rdata_o[3:2]}, {6'd0, m_req});
        cmp("R5", "ctrl bits", {6'd0, rdata_o[1:0]}, {6'd0, m_pwr, m_lock});
      end else if (addr_i == 2'd1) begin
        cmp("R1", "presence", {6'd0, rdata_o[3:2]}, {6'd0, ~mf[1], ~mf[0]});
        cmp("R2", "chg flag", {7'd0, rdata_o[0]}, {7'd0, m_chg});
        cmp("R7", "rem flag", {7'd0, rdata_o[1]}, {7'd0, m_rem});
        cmp("R3", "state", {6'd0, rdata_o[5:4]}, {6'd0, m_state});
      end
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    @(negedge clk_i); addr_i = a; #1.5; v = rdata_o;
  endtask

  task automatic chk(string req, string what, logic [7:0] got, logic [7:0] exp);
    cmp(req, what, got, exp);
  endtask

  task automatic led_ones(output int ones);
    ones = 0;
    repeat (16) begin @(negedge clk_i); #1.5; ones += int'(led_o); end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++; done = 1'b1;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int ones;
    #12 @(negedge clk_i); rst_ni = 1'b1;
    // R11 reset values
    rd(2'd0, v); chk("R11", "ctrl after reset", v, 8'h00);
    rd(2'd1, v); chk("R11", "status after reset", v, 8'h00);
    chk("R11", "led after reset", {7'd0, led_o}, 8'h00);

    // R1 glitch shorter than debounce
    @(negedge clk_i); prsn_usb_ni = 1'b0; idle(2); prsn_usb_ni = 1'b1; idle(12);
    rd(2'd1, v); chk("R1", "glitch ignored", v, 8'h00);

    // R4 request while empty ignored, but read back
    wr(2'd0, 8'h04); idle(2);
    rd(2'd1, v); chk("R4", "state w/o device", {6'd0, v[5:4]}, 8'h00);
    rd(2'd0, v); chk("R4", "req readback", {6'd0, v[3:2]}, 8'h01);

    // R1/R2/R3 insertion
    @(negedge clk_i); prsn_usb_ni = 1'b0; idle(12);
    rd(2'd1, v); chk("R1", "usb present", {6'd0, v[3:2]}, 8'h01);
    chk("R2", "chg set", {7'd0, v[0]}, 8'h01);
    chk("R3", "still empty", {6'd0, v[5:4]}, 8'h00);
    chk("R8", "irq on chg", {7'd0, irq_o}, 8'h01);
    wr(2'd1, 8'h01); idle(1);
    rd(2'd1, v); chk("R2", "chg cleared", {7'd0, v[0]}, 8'h00);

    // R5 power without lock blocked; R4 request with device
    wr(2'd0, 8'h06); idle(1);
    chk("R5", "pwr blocked", {7'd0, pwr_o}, 8'h00);
    rd(2'd1, v); chk("R4", "inserted", {6'd0, v[5:4]}, 8'h01);
    led_ones(ones); chk("R9", "blink inserted", 8'(ones), 8'd8);

    wr(2'd0, 8'h0B); idle(1);
    chk("R5", "pwr on", {7'd0, pwr_o}, 8'h01);
    led_ones(ones); chk("R9", "solid powered", 8'(ones), 8'd16);
    wr(2'd0, 8'h02); idle(1);
    chk("R5", "lock drop clears pwr", {6'd0, pwr_o, lock_o}, 8'h00);

    // R6 override
    wr(2'd0, 8'h03);
    @(negedge clk_i); override_i = 1'b1; idle(2);
    chk("R6", "override clears", {7'd0, pwr_o}, 8'h00);
    wr(2'd0, 8'h03); idle(1);
    chk("R6", "write under override", {7'd0, pwr_o}, 8'h00);
    @(negedge clk_i); override_i = 1'b0;
    wr(2'd0, 8'h03); idle(1);
    chk("R6", "pwr after override", {7'd0, pwr_o}, 8'h01);

    // R7 button
    @(negedge clk_i); rem_btn_i = 1'b1; idle(10); rem_btn_i = 1'b0; idle(10);
    rd(2'd1, v); chk("R7", "rem event", {7'd0, v[1]}, 8'h01);
    chk("R7", "pwr kept", {6'd0, pwr_o, lock_o}, 8'h03);
    led_ones(ones); chk("R9", "blink removal", 8'(ones), 8'd8);
    @(negedge clk_i); low_pwr_i = 1'b1;
    led_ones(ones); chk("R10", "low power dark", 8'(ones), 8'd0);
    @(negedge clk_i); low_pwr_i = 1'b0;
    wr(2'd1, 8'h02); idle(1);
    chk("R8", "irq cleared", {7'd0, irq_o}, 8'h00);

    // R4 zero request no effect; R9 off after power removed
    wr(2'd0, 8'h0C); wr(2'd0, 8'h00); idle(1);
    rd(2'd0, v); chk("R4", "req keeps 3", v, 8'h0C);
    rd(2'd1, v); chk("R4", "state removing", {6'd0, v[5:4]}, 8'h03);
    led_ones(ones); chk("R9", "off unpowered", 8'(ones), 8'd0);

    // both interfaces, then removal
    wr(2'd0, 8'h0B);
    @(negedge clk_i); prsn_fw_ni = 1'b0; idle(12);
    rd(2'd1, v); chk("R1", "both present", {6'd0, v[3:2]}, 8'h03);
    wr(2'd1, 8'h01);
    @(negedge clk_i); prsn_usb_ni = 1'b1; prsn_fw_ni = 1'b1; idle(12);
    rd(2'd1, v); chk("R3", "empty on removal", {6'd0, v[5:4]}, 8'h00);
    chk("R2", "chg on removal", {7'd0, v[0]}, 8'h01);
    chk("R3", "pwr off on removal", {7'd0, pwr_o}, 8'h00);
    idle(4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule